// File: doc/BRIEF.md
# Chained FIFO slice controller with ownership tokens

This block joins N identical FIFO slices, each with its own small storage array, into one first-in first-out queue that is N times deeper. Two tokens circulate around a ring of slices: the write token marks the slice that takes the next incoming word, and the read token marks the slice that supplies the next outgoing word. A slice passes a token to its neighbour when it writes or reads its own last physical location. The ring starts at one slice chosen by a first-load strap, and tokens move upward by slice index, wrapping from the highest index back to slice 0. Because every slice is filled and drained in complete passes, each slice only needs a local pointer pair and an occupancy count.

Callers see a single queue: a write strobe with a data word, a read strobe, a registered read result with a valid bit, and composite full and empty flags. A slice raises its own full or empty flag only while it holds the matching token. The composite flags are the OR of the per-slice flags. The current owner of each token is brought out as a one-hot vector, so the enable that gates each slice can be seen. Retransmit and half-full reporting are absent, because the slices always run in chained mode.

Top module: `xc_fifo`

## Requirements
- R1: One clock cycle after a synchronous reset, `chain_empty` is 1, `chain_full` is 0 and `rd_valid` is 0. `wr_owner` and `rd_owner` are both the one-hot code with bit `FIRST_SLICE` set.
- R2: A write strobe is taken whenever the chain is not full, into the slice whose bit is set in `wr_owner`. That slice's locations are used in order from 0 to `DEPTH-1`. In the cycle after the write to location `DEPTH-1`, `wr_owner` has moved to the next slice.
- R3: A read strobe is taken whenever the chain is not empty, from the slice whose bit is set in `rd_owner`, in location order. In the cycle after the read of location `DEPTH-1`, `rd_owner` has moved to the next slice.
- R4: Token passing forms a ring. The slice after index i is index (i+1) mod `N_SLICES`, so the slice with the highest index hands over to slice 0.
- R5: In the cycle after a read is taken, `rd_valid` is 1 and `rd_data` holds the oldest word not yet read. This holds across slice boundaries. In any cycle after which no read was taken, `rd_valid` is 0.
- R6: `chain_full` is 1 exactly when `N_SLICES*DEPTH` words are held. A write strobe while full is dropped: stored contents and `wr_owner` stay the same.
- R7: `chain_empty` is 1 exactly when no word is held. A read strobe while empty is dropped: `rd_valid` stays 0 and `rd_owner` stays the same.
- R8: A read and a write in the same cycle both take effect when the chain is neither full nor empty, and the occupancy stays the same. When full, only the read is taken. When empty, only the write is taken, and the new word cannot be read in that same cycle.
- R9: At every cycle, exactly one bit of `wr_owner` and exactly one bit of `rd_owner` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the whole chain |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Word to be written |
| rd_en | input | 1 | Read strobe |
| rd_data | output | WIDTH | Word read, valid when `rd_valid` is 1 |
| rd_valid | output | 1 | A read was taken on the previous edge |
| chain_full | output | 1 | Composite full flag |
| chain_empty | output | 1 | Composite empty flag |
| wr_owner | output | N_SLICES | One-hot holder of the write token |
| rd_owner | output | N_SLICES | One-hot holder of the read token |

## Verification
Two functions can fall in the same cycle. In the first, a write hands the write token across a link while a read, taken in the same cycle, hands the read token across another link. In the second, a read and a write strike the same slice when the chain is exactly full or exactly empty. The bench fills the chain to capacity and then drains it, issuing a read and a write together at both extremes, and then runs long stretches of random, dense strobes that make both tokens cross boundaries in the same cycle. A behavioural queue with running write and read totals predicts the flags, the read word and both owner vectors on every clock, and these are compared with the design's outputs at the falling edge.

// File: rtl/xc_pkg.sv
// Shared types for the chained FIFO.
// Assumes: nothing beyond standard SystemVerilog.
package xc_pkg;

    // Handoff signals carried on one link between neighbouring slices.
    // Each field is a single-cycle pulse; separate fields tell the
    // receiver which token has arrived.
    typedef struct packed {
        logic wr_pass;
        logic rd_pass;
    } xc_link_t;

    // Index of the slice that follows 'idx' around the ring.
    function automatic int unsigned ring_next(input int unsigned idx,
                                              input int unsigned n);
        return (idx + 1) % n;
    endfunction

endpackage

// File: rtl/xc_slice_ram.sv
// Behavioural storage for one slice: one write port and one
// registered read port.
// Assumes: the controller never asserts rd_fire on an empty location.
// q_valid marks the cycle after a read so that the merge logic can
// select this slice's word.
module xc_slice_ram #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned WIDTH = 9,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_fire,
    input  logic [PTR_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rd_fire,
    input  logic [PTR_W-1:0] raddr,
    output logic [WIDTH-1:0] q,
    output logic             q_valid
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Store the incoming word at the write location.
    always_ff @(posedge clk) begin
        if (wr_fire) begin
            mem[waddr] <= wdata;
        end
    end

    // Register the word at the read location and flag it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q_valid <= 1'b0;
        end else begin
            q_valid <= rd_fire;
            if (rd_fire) begin
                q <= mem[raddr];
            end
        end
    end

endmodule

// File: rtl/xc_slice_ctrl.sv
// Token and pointer control for one slice of the chain.
// A strobe fires only while this slice holds the matching token and
// its local storage allows it. Writing or reading the last physical
// location emits a handoff pulse in that same cycle. The neighbour
// registers the token on the same edge, so the next strobe finds the
// new owner with no idle cycle.
// Assumes: exactly one slice in the ring has strap_first_n low.
module xc_slice_ctrl
    import xc_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_first_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  xc_link_t         xin,
    output xc_link_t         xout,
    output logic             own_wr,
    output logic             own_rd,
    output logic             wr_fire,
    output logic             rd_fire,
    output logic [PTR_W-1:0] waddr,
    output logic [PTR_W-1:0] raddr,
    output logic             slice_full,
    output logic             slice_empty
);

    localparam logic [PTR_W-1:0] LAST_LOC = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP      = CNT_W'(DEPTH);

    logic [CNT_W-1:0] cnt;
    logic             local_full;
    logic             local_empty;

    // Local occupancy tests.
    always_comb begin
        local_full  = (cnt == CAP);
        local_empty = (cnt == '0);
    end

    // Gate the strobes by token ownership and local room or content.
    always_comb begin
        wr_fire = wr_en && own_wr && !local_full;
        rd_fire = rd_en && own_rd && !local_empty;
    end

    // Raise a handoff pulse when the last location is touched.
    always_comb begin
        xout.wr_pass = wr_fire && (waddr == LAST_LOC);
        xout.rd_pass = rd_fire && (raddr == LAST_LOC);
    end

    // Report flags only while holding the relevant token.
    always_comb begin
        slice_full  = own_wr && local_full;
        slice_empty = own_rd && local_empty;
    end

    // Track token ownership: give away on own pulse, take on neighbour's.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_wr <= !strap_first_n;
            own_rd <= !strap_first_n;
        end else begin
            own_wr <= (own_wr && !xout.wr_pass) || xin.wr_pass;
            own_rd <= (own_rd && !xout.rd_pass) || xin.rd_pass;
        end
    end

    // Advance the local pointers, wrapping after the last location.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waddr <= '0;
            raddr <= '0;
        end else begin
            if (wr_fire) begin
                waddr <= (waddr == LAST_LOC) ? '0 : waddr + 1'b1;
            end
            if (rd_fire) begin
                raddr <= (raddr == LAST_LOC) ? '0 : raddr + 1'b1;
            end
        end
    end

    // Keep the local word count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr_fire && !rd_fire) begin
            cnt <= cnt + 1'b1;
        end else if (rd_fire && !wr_fire) begin
            cnt <= cnt - 1'b1;
        end
    end

    // The count never goes above the slice depth.
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CAP);

    // A full slice that is not read stays full, whatever is written.
    assert_full_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (local_full && !rd_fire) |=> local_full);

    // An empty slice that is not written stays empty, whatever is read.
    assert_empty_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (local_empty && !wr_fire) |=> local_empty);

    // A slice that hands on the write token no longer holds it unless it
    // receives it back in the same cycle.
    assert_wr_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (xout.wr_pass && !xin.wr_pass) |=> !own_wr);

endmodule

// File: rtl/xc_merge.sv
// Chain-level merge: composite flags and read-word selection.
// A slice flag is only raised by the token holder, so an OR over
// slices gives the chain's state. At most one slice drives q_valid in
// any cycle, so the read words are OR-merged after gating.
// Assumes: only one slice reads per cycle.
module xc_merge #(
    parameter int unsigned N_SLICES = 4,
    parameter int unsigned WIDTH    = 9
) (
    input  logic [N_SLICES-1:0]            full_v,
    input  logic [N_SLICES-1:0]            empty_v,
    input  logic [N_SLICES-1:0]            qv_v,
    input  logic [N_SLICES-1:0][WIDTH-1:0] q_v,
    output logic                           chain_full,
    output logic                           chain_empty,
    output logic                           rd_valid,
    output logic [WIDTH-1:0]               rd_data
);

    // Reduce the per-slice flags.
    always_comb begin
        chain_full  = |full_v;
        chain_empty = |empty_v;
        rd_valid    = |qv_v;
    end

    // Select the word from the slice that just read.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < int'(N_SLICES); i++) begin
            rd_data = rd_data | (q_v[i] & {WIDTH{qv_v[i]}});
        end
    end

endmodule

// File: rtl/xc_fifo.sv
// Top of the chained FIFO: N_SLICES slices joined in a ring.
// Slice i passes its tokens to slice (i+1) mod N_SLICES. The slice at
// FIRST_SLICE is strapped as the first device and owns both tokens
// after reset.
// Assumes: FIRST_SLICE < N_SLICES and DEPTH >= 2.
module xc_fifo
    import xc_pkg::*;
#(
    parameter int unsigned N_SLICES    = 4,
    parameter int unsigned DEPTH       = 8,
    parameter int unsigned WIDTH       = 9,
    parameter int unsigned FIRST_SLICE = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WIDTH-1:0]    wr_data,
    input  logic                rd_en,
    output logic [WIDTH-1:0]    rd_data,
    output logic                rd_valid,
    output logic                chain_full,
    output logic                chain_empty,
    output logic [N_SLICES-1:0] wr_owner,
    output logic [N_SLICES-1:0] rd_owner
);

    localparam int unsigned PTR_W = $clog2(DEPTH);

    xc_link_t                      link_out [N_SLICES];
    xc_link_t                      link_in  [N_SLICES];
    logic [N_SLICES-1:0]           full_v;
    logic [N_SLICES-1:0]           empty_v;
    logic [N_SLICES-1:0]           qv_v;
    logic [N_SLICES-1:0][WIDTH-1:0] q_v;

    for (genvar i = 0; i < int'(N_SLICES); i++) begin : g_slice
        localparam int unsigned NXT = ring_next(i, N_SLICES);
        localparam logic STRAP_N = (i == int'(FIRST_SLICE)) ? 1'b0 : 1'b1;

        logic             wr_fire;
        logic             rd_fire;
        logic [PTR_W-1:0] waddr;
        logic [PTR_W-1:0] raddr;

        // Close the ring: this slice's output feeds the next one's input.
        assign link_in[NXT] = link_out[i];

        xc_slice_ctrl #(
            .DEPTH (DEPTH)
        ) u_ctrl (
            .clk           (clk),
            .rst_n         (rst_n),
            .strap_first_n (STRAP_N),
            .wr_en         (wr_en),
            .rd_en         (rd_en),
            .xin           (link_in[i]),
            .xout          (link_out[i]),
            .own_wr        (wr_owner[i]),
            .own_rd        (rd_owner[i]),
            .wr_fire       (wr_fire),
            .rd_fire       (rd_fire),
            .waddr         (waddr),
            .raddr         (raddr),
            .slice_full    (full_v[i]),
            .slice_empty   (empty_v[i])
        );

        xc_slice_ram #(
            .DEPTH (DEPTH),
            .WIDTH (WIDTH)
        ) u_ram (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_fire (wr_fire),
            .waddr   (waddr),
            .wdata   (wr_data),
            .rd_fire (rd_fire),
            .raddr   (raddr),
            .q       (q_v[i]),
            .q_valid (qv_v[i])
        );

        // A write handoff pulse puts the write token on the next slice.
        assert_wr_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
            link_out[i].wr_pass |=> wr_owner[NXT]);

        // A read handoff pulse puts the read token on the next slice.
        assert_rd_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
            link_out[i].rd_pass |=> rd_owner[NXT]);
    end

    xc_merge #(
        .N_SLICES (N_SLICES),
        .WIDTH    (WIDTH)
    ) u_merge (
        .full_v      (full_v),
        .empty_v     (empty_v),
        .qv_v        (qv_v),
        .q_v         (q_v),
        .chain_full  (chain_full),
        .chain_empty (chain_empty),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data)
    );

    // Each token has exactly one holder.
    assert_wr_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_owner) == 1);
    assert_rd_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd_owner) == 1);

    // The chain cannot be full and empty at once.
    assert_flags_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(chain_full && chain_empty));

    // A read strobe on an empty chain yields no word.
    assert_empty_no_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chain_empty |=> !rd_valid);

    // A word only appears after a read strobe.
    assert_word_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en));

endmodule

// File: tb/sim_xc_fifo.sv
// Bench for the chained FIFO. A behavioural queue plus running write
// and read totals predict the flags, the read word and the token
// owners, and these are compared at every falling edge.
module sim_xc_fifo;

    localparam int unsigned N     = 4;
    localparam int unsigned D     = 4;
    localparam int unsigned W     = 9;
    localparam int unsigned FIRST = 1;
    localparam int          CAP   = N * D;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_en = 1'b0;
    logic [W-1:0] rd_data;
    logic         rd_valid;
    logic         chain_full;
    logic         chain_empty;
    logic [N-1:0] wr_owner;
    logic [N-1:0] rd_owner;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    logic [W-1:0] model_q [$];
    int           wtot = 0;
    int           rtot = 0;
    logic         exp_valid = 1'b0;
    logic [W-1:0] exp_data = '0;

    always #5 clk = ~clk;

    xc_fifo #(
        .N_SLICES    (N),
        .DEPTH       (D),
        .WIDTH       (W),
        .FIRST_SLICE (FIRST)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_en       (rd_en),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid),
        .chain_full  (chain_full),
        .chain_empty (chain_empty),
        .wr_owner    (wr_owner),
        .rd_owner    (rd_owner)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fails = n_fails + 1;
            $display("FAIL R5 watchdog expired actual=%0d expected<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    function automatic logic [N-1:0] owner_of(input int total);
        return N'(1) << ((FIRST + total / D) % N);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fails = n_fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare every output with the model; called at a falling edge.
    task automatic check_all();
        check("R6 chain_full",  32'(chain_full),  32'(model_q.size() == CAP));
        check("R7 chain_empty", 32'(chain_empty), 32'(model_q.size() == 0));
        check("R5 rd_valid",    32'(rd_valid),    32'(exp_valid));
        if (exp_valid) check("R5 rd_data order", 32'(rd_data), 32'(exp_data));
        check("R2 R4 wr_owner", 32'(wr_owner), 32'(owner_of(wtot)));
        check("R3 R4 rd_owner", 32'(rd_owner), 32'(owner_of(rtot)));
        check("R9 wr_owner onehot", 32'($countones(wr_owner)), 32'd1);
        check("R9 rd_owner onehot", 32'($countones(rd_owner)), 32'd1);
    endtask

    // One clock cycle: check, drive, advance the model past the edge.
    task automatic cycle(input logic we, input logic re, input logic [W-1:0] d);
        logic wacc;
        logic racc;
        check_all();
        wr_en   = we;
        rd_en   = re;
        wr_data = d;
        wacc = we && (model_q.size() < CAP);
        racc = re && (model_q.size() > 0);
        @(posedge clk);
        #1;
        exp_valid = racc;
        if (racc) begin
            exp_data = model_q.pop_front();
            rtot = rtot + 1;
        end
        if (wacc) begin
            model_q.push_back(d);
            wtot = wtot + 1;
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        rd_en = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        model_q.delete();
        wtot = 0;
        rtot = 0;
        exp_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        // Reset state (R1).
        check("R1 empty after reset", 32'(chain_empty), 32'd1);
        check("R1 full after reset",  32'(chain_full),  32'd0);
        check("R1 valid after reset", 32'(rd_valid),    32'd0);
        check("R1 wr_owner after reset", 32'(wr_owner), 32'(N'(1) << FIRST));
        check("R1 rd_owner after reset", 32'(rd_owner), 32'(N'(1) << FIRST));
    endtask

    initial begin
        do_reset();

        // Read on an empty chain is dropped (R7).
        cycle(1'b0, 1'b1, '0);
        check("R7 read on empty gives no word", 32'(rd_valid), 32'd0);
        check("R7 rd_owner unchanged", 32'(rd_owner), 32'(N'(1) << FIRST));

        // Read and write together on empty: only the write is taken (R8).
        cycle(1'b1, 1'b1, 9'h15A);
        check("R8 empty: read dropped", 32'(rd_valid), 32'd0);
        check("R8 empty: write kept", 32'(chain_empty), 32'd0);

        // Fill to capacity, crossing every slice boundary and the wrap (R2, R4).
        for (int k = 1; k < CAP; k++) cycle(1'b1, 1'b0, W'(k * 37 + 5));
        check("R6 full at capacity", 32'(chain_full), 32'd1);
        check("R4 wr token wrapped to first", 32'(wr_owner), 32'(N'(1) << FIRST));

        // Writes while full are dropped (R6).
        for (int k = 0; k < 3; k++) cycle(1'b1, 1'b0, 9'h1FF);
        check("R6 full held", 32'(chain_full), 32'd1);
        check("R6 wr_owner unchanged", 32'(wr_owner), 32'(N'(1) << FIRST));

        // Read and write together on full: only the read is taken (R8).
        cycle(1'b1, 1'b1, 9'h0AA);
        check("R8 full: read taken", 32'(rd_valid), 32'd1);
        check("R8 full: read word", 32'(rd_data), 32'h15A);
        check("R8 full: write dropped", 32'(chain_full), 32'd0);

        // Drain completely, crossing all read boundaries (R3, R5).
        for (int k = 0; k < CAP + 2; k++) cycle(1'b0, 1'b1, '0);
        check("R7 empty after drain", 32'(chain_empty), 32'd1);

        // Steady stream with read and write together, part filled (R8).
        for (int k = 0; k < 5; k++) cycle(1'b1, 1'b0, W'(k + 100));
        for (int k = 0; k < 3 * CAP; k++) cycle(1'b1, 1'b1, W'(k + 200));
        check("R8 occupancy kept", 32'(chain_empty || chain_full), 32'd0);

        // Dense random strobes so both tokens move in the same cycles.
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r;
            r = $urandom;
            cycle(r[0] | r[1], r[2] | (r[3] & r[4]), W'(r[31:16]));
        end
        // Sparse random strobes to reach the extremes from both sides.
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r;
            r = $urandom;
            cycle(r[0] & r[5], r[1] & r[6] & r[7], W'(r[31:16]));
        end

        // Reset with data inside (R1), then run again.
        for (int k = 0; k < 7; k++) cycle(1'b1, 1'b0, W'(k));
        do_reset();
        for (int k = 0; k < 200; k++) begin
            logic [31:0] r;
            r = $urandom;
            cycle(r[0], r[1], W'(r[31:16]));
        end
        check_all();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule